// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block turns the geometry of one scaled plane into the setup values of a polyphase scaling engine. It takes the source width and height in unsigned 16.16 fixed point and the destination width and height as integers. From them it produces the horizontal and vertical upscale factors (U16.16), the initial phase and delta phase for each direction, and an enhancer enable for strong upscales.

A single restoring divider (64-bit dividend, 32-bit divisor, one quotient bit per clock) is reused for all six divisions. They run in a fixed order: horizontal factor, vertical factor, horizontal initial phase, horizontal delta phase, vertical initial phase, vertical delta phase. A one-cycle `start` begins a request. The plane mask is classified first. An empty mask means scaling is off and nothing is computed. A mask with more than one bit set is refused, because the engine serves only one plane. A one-cycle `done` ends every accepted request.

Top module: `scl_phase_calc`

## Requirements
- R1: After reset, `busy`, `done`, `rejected`, `div_zero`, `scale_en`, `enh_en` and all six result outputs are zero.
- R2: A `start` seen while idle with two or more bits set in `plane_mask` raises `done` and `rejected` in the next cycle. In that cycle `scale_en` is 0 and all results are zero, and no division is run.
- R3: A `start` seen while idle with `plane_mask` all zero raises `done` in the next cycle. In that cycle `rejected` and `scale_en` are 0 and all results are zero.
- R4: `h_factor` equals the low 32 bits of (`dst_w` << 32) / `src_w`, and `v_factor` likewise uses `dst_h` and `src_h`.
- R5: With in = source size >> 16, the initial phase for each direction equals ((in << 4) / dst + 1) / 2, using truncating division at each step.
- R6: The delta phase for each direction equals (in << 16) / dst.
- R7: `enh_en` is 1 exactly when bits 31:16 of `h_factor` or of `v_factor` are 2 or more.
- R8: With a one-hot mask and no zero divisor, `busy` rises right after the start edge. `done` and `scale_en` are 1 exactly 396 clock edges after the start edge (6 divisions of 66 cycles each), `done` lasts one cycle, and `busy` is low in that cycle.
- R9: A zero divisor stops the sequence at that division. Divisions are indexed k = 0..5 in the order above. `done` and `div_zero` are 1 exactly 2 + 66k edges after the start edge, with `scale_en` and `enh_en` at 0.
- R10: A `start` that arrives while `busy` is high is ignored. The running request's timing and results are unchanged.
- R11: Results and flags hold their values while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| plane_mask | input | 4 | One bit per plane that asks for scaling |
| src_w | input | 32 | Source width, unsigned 16.16 |
| src_h | input | 32 | Source height, unsigned 16.16 |
| dst_w | input | 16 | Destination width in pixels |
| dst_h | input | 16 | Destination height in pixels |
| busy | output | 1 | A request is being computed |
| done | output | 1 | One-cycle end-of-request pulse |
| rejected | output | 1 | Request refused: more than one plane in the mask |
| div_zero | output | 1 | Request aborted on a zero divisor |
| scale_en | output | 1 | Scaling results are valid and scaling is on |
| enh_en | output | 1 | Enhancer enable |
| h_factor | output | 32 | Horizontal upscale factor, U16.16 |
| v_factor | output | 32 | Vertical upscale factor, U16.16 |
| h_init | output | 32 | Horizontal initial phase |
| h_delta | output | 32 | Horizontal delta phase |
| v_init | output | 32 | Vertical initial phase |
| v_delta | output | 32 | Vertical delta phase |

## Verification
Faults can show up in three places. A wrong step counter or sequencing state in the divider changes the cycle on which `done` appears. The per-clock comparison reports that on the first cycle where `done` or `busy` differs from the 66-cycle-per-division schedule. A wrong remainder or dividend selection leaves the timing correct but corrupts a result value, and this shows up when `done` is high. A result register that changes outside a capture shows up during the idle cycles that follow, because the outputs are compared again on every idle clock.

// File: rtl/scl_pkg.sv
// Package: shared state type and the fixed division order for the
// scaler phase calculator. Assumes six divisions per request.
package scl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } scl_state_e;

    localparam int NUM_DIV  = 6;
    localparam int IDX_HFAC = 0;
    localparam int IDX_VFAC = 1;
    localparam int IDX_HINI = 2;
    localparam int IDX_HDEL = 3;
    localparam int IDX_VINI = 4;
    localparam int IDX_VDEL = 5;
endpackage

// File: rtl/scl_mask_class.sv
// Classifies the plane mask as empty or as holding more than one
// plane. Purely combinational; assumes the mask is stable when sampled.
module scl_mask_class #(
    parameter int NPLANES = 4
) (
    input  logic [NPLANES-1:0] mask,
    output logic               none,
    output logic               multi
);
    localparam int CW = $clog2(NPLANES + 1);

    logic [CW-1:0] ones;

    // Count the set bits of the mask.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NPLANES; i++) begin
            ones = ones + CW'(mask[i]);
        end
    end

    assign none  = (ones == '0);
    assign multi = (ones > CW'(1));
endmodule

// File: rtl/scl_restoring_div.sv
// Sequential restoring divider: one quotient bit per clock.
// A go pulse loads the operands. A zero divisor answers on the next
// cycle with dz set. Otherwise valid pulses after NUM_W step cycles.
// Assumes go is only raised while the divider is idle.
module scl_restoring_div #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic             dz,
    output logic [DEN_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] q_q;
    logic [CW-1:0]    cnt_q;
    logic             active_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    // One restoring step: shift in the next dividend bit, trial-subtract.
    always_comb begin
        shifted = {rem_q, q_q[NUM_W-1]};
        diff    = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
    end

    // Load on go, then iterate until the step counter runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            den_q    <= '0;
            q_q      <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            valid    <= 1'b0;
            dz       <= 1'b0;
        end else begin
            valid <= 1'b0;
            dz    <= 1'b0;
            if (go) begin
                rem_q <= '0;
                den_q <= den;
                q_q   <= num;
                if (den == '0) begin
                    valid <= 1'b1;
                    dz    <= 1'b1;
                end else begin
                    cnt_q    <= CW'(NUM_W);
                    active_q <= 1'b1;
                end
            end else if (active_q) begin
                rem_q <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                q_q   <= {q_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    active_q <= 1'b0;
                    valid    <= 1'b1;
                end
            end
        end
    end

    assign quo = q_q[DEN_W-1:0];
endmodule

// File: rtl/scl_phase_calc.sv
// Top: sequences the six divisions that produce the scaler setup values.
// The mask is screened on start. Operands are latched, and each quotient
// is captured into its result slot. Initial phases are rounded by
// (q + 1) / 2. Assumes src sizes are 16.16 and dst sizes are integers.
module scl_phase_calc
    import scl_pkg::*;
#(
    parameter int NPLANES     = 4,
    parameter int SRC_W       = 32,
    parameter int FRAC_W      = 16,
    parameter int DST_W       = 16,
    parameter int PHASE_BITS  = 4,
    parameter int PHASE_SHIFT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NPLANES-1:0] plane_mask,
    input  logic [SRC_W-1:0]   src_w,
    input  logic [SRC_W-1:0]   src_h,
    input  logic [DST_W-1:0]   dst_w,
    input  logic [DST_W-1:0]   dst_h,
    output logic               busy,
    output logic               done,
    output logic               rejected,
    output logic               div_zero,
    output logic               scale_en,
    output logic               enh_en,
    output logic [SRC_W-1:0]   h_factor,
    output logic [SRC_W-1:0]   v_factor,
    output logic [SRC_W-1:0]   h_init,
    output logic [SRC_W-1:0]   h_delta,
    output logic [SRC_W-1:0]   v_init,
    output logic [SRC_W-1:0]   v_delta
);
    localparam int NUM_W   = 2 * SRC_W;
    localparam int INT_W   = SRC_W - FRAC_W;
    localparam int IW      = $clog2(NUM_DIV);
    localparam int DEL_SH  = PHASE_BITS + PHASE_SHIFT;

    scl_state_e       st_q;
    logic [IW-1:0]    idx_q;
    logic [SRC_W-1:0] sw_q, sh_q;
    logic [DST_W-1:0] dw_q, dh_q;
    logic [INT_W-1:0] in_w, in_h;
    logic             m_none, m_multi;
    logic             go;
    logic [NUM_W-1:0] num;
    logic [SRC_W-1:0] den;
    logic             d_valid, d_dz;
    logic [SRC_W-1:0] d_quo;
    logic [SRC_W-1:0] cap_val;
    logic             cap;
    logic             clr;
    logic [SRC_W-1:0] res [NUM_DIV];
    logic             enh_calc;

    scl_mask_class #(.NPLANES(NPLANES)) u_mask (
        .mask  (plane_mask),
        .none  (m_none),
        .multi (m_multi)
    );

    assign in_w = sw_q[SRC_W-1:FRAC_W];
    assign in_h = sh_q[SRC_W-1:FRAC_W];
    assign go   = (st_q == ST_LAUNCH);
    assign busy = (st_q != ST_IDLE);
    assign clr  = (st_q == ST_IDLE) && start;
    assign cap  = (st_q == ST_WAIT) && d_valid && !d_dz;

    // Select dividend and divisor for the current division index.
    always_comb begin
        num = '0;
        den = '0;
        case (int'(idx_q))
            IDX_HFAC: begin num = NUM_W'(dw_q) << SRC_W;      den = sw_q;         end
            IDX_VFAC: begin num = NUM_W'(dh_q) << SRC_W;      den = sh_q;         end
            IDX_HINI: begin num = NUM_W'(in_w) << PHASE_BITS; den = SRC_W'(dw_q); end
            IDX_HDEL: begin num = NUM_W'(in_w) << DEL_SH;     den = SRC_W'(dw_q); end
            IDX_VINI: begin num = NUM_W'(in_h) << PHASE_BITS; den = SRC_W'(dh_q); end
            IDX_VDEL: begin num = NUM_W'(in_h) << DEL_SH;     den = SRC_W'(dh_q); end
            default:  begin num = '0;                         den = '0;           end
        endcase
    end

    scl_restoring_div #(.NUM_W(NUM_W), .DEN_W(SRC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .num   (num),
        .den   (den),
        .valid (d_valid),
        .dz    (d_dz),
        .quo   (d_quo)
    );

    // Round initial phases to half; pass other quotients through.
    always_comb begin
        if (int'(idx_q) == IDX_HINI || int'(idx_q) == IDX_VINI) begin
            cap_val = SRC_W'(({1'b0, d_quo} + (SRC_W+1)'(1)) >> 1);
        end else begin
            cap_val = d_quo;
        end
    end

    // One register per result slot, cleared on accepted start.
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                res[g] <= '0;
            end else if (cap && int'(idx_q) == g) begin
                res[g] <= cap_val;
            end
        end
    end

    assign enh_calc = (res[IDX_HFAC][SRC_W-1:FRAC_W] >= INT_W'(2)) ||
                      (res[IDX_VFAC][SRC_W-1:FRAC_W] >= INT_W'(2));

    // Request sequencer: screen mask, launch and collect each division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            idx_q    <= '0;
            sw_q     <= '0;
            sh_q     <= '0;
            dw_q     <= '0;
            dh_q     <= '0;
            done     <= 1'b0;
            rejected <= 1'b0;
            div_zero <= 1'b0;
            scale_en <= 1'b0;
            enh_en   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        rejected <= 1'b0;
                        div_zero <= 1'b0;
                        scale_en <= 1'b0;
                        enh_en   <= 1'b0;
                        if (m_none) begin
                            done <= 1'b1;
                        end else if (m_multi) begin
                            done     <= 1'b1;
                            rejected <= 1'b1;
                        end else begin
                            sw_q  <= src_w;
                            sh_q  <= src_h;
                            dw_q  <= dst_w;
                            dh_q  <= dst_h;
                            idx_q <= '0;
                            st_q  <= ST_LAUNCH;
                        end
                    end
                end
                ST_LAUNCH: begin
                    st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (d_valid) begin
                        if (d_dz) begin
                            div_zero <= 1'b1;
                            done     <= 1'b1;
                            st_q     <= ST_IDLE;
                        end else if (int'(idx_q) == NUM_DIV - 1) begin
                            done     <= 1'b1;
                            scale_en <= 1'b1;
                            enh_en   <= enh_calc;
                            st_q     <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                            st_q  <= ST_LAUNCH;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign h_factor = res[IDX_HFAC];
    assign v_factor = res[IDX_VFAC];
    assign h_init   = res[IDX_HINI];
    assign h_delta  = res[IDX_HDEL];
    assign v_init   = res[IDX_VINI];
    assign v_delta  = res[IDX_VDEL];
endmodule

// File: rtl/scl_phase_calc_chk.sv
// Checker for scl_phase_calc: port-level timing and flag properties.
// Assumes synchronous active-low reset on rst_n.
module scl_phase_calc_chk #(
    parameter int NPLANES = 4,
    parameter int SRC_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [NPLANES-1:0] plane_mask,
    input logic               busy,
    input logic               done,
    input logic               rejected,
    input logic               div_zero,
    input logic               scale_en,
    input logic               enh_en,
    input logic [SRC_W-1:0]   h_factor,
    input logic [SRC_W-1:0]   v_delta
);
    // R2: multi-plane request refused on the next cycle
    a_r2_multi_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && $countones(plane_mask) > 1) |=> (done && rejected && !scale_en));

    // R3: empty mask finishes next cycle with scaling off
    a_r3_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && plane_mask == '0) |=> (done && !rejected && !scale_en && h_factor == '0));

    // R8: done is a single-cycle pulse and never overlaps busy
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: abort flag appears only with done and never with scale_en
    a_r9_dz_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_zero) |-> (done && !scale_en && !enh_en));

    // R10: once busy, stays busy until the done pulse
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R11: outputs hold while idle with no start
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(h_factor) && $stable(v_delta) && $stable(scale_en)));
endmodule

bind scl_phase_calc scl_phase_calc_chk #(.NPLANES(NPLANES), .SRC_W(SRC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .plane_mask (plane_mask),
    .busy       (busy),
    .done       (done),
    .rejected   (rejected),
    .div_zero   (div_zero),
    .scale_en   (scale_en),
    .enh_en     (enh_en),
    .h_factor   (h_factor),
    .v_delta    (v_delta)
);

// File: tb/scl_phase_calc_bench.sv
module scl_phase_calc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  plane_mask = '0;
    logic [31:0] src_w = '0, src_h = '0;
    logic [15:0] dst_w = '0, dst_h = '0;
    logic        busy, done, rejected, div_zero, scale_en, enh_en;
    logic [31:0] h_factor, v_factor, h_init, h_delta, v_init, v_delta;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // expected model state
    logic [31:0] e_res [6];
    bit          e_rej, e_dz, e_sc, e_enh;
    bit          e_res_known;

    always #4 clk = ~clk;

    scl_phase_calc u_scl_phase_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .plane_mask(plane_mask),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .busy(busy), .done(done), .rejected(rejected), .div_zero(div_zero),
        .scale_en(scale_en), .enh_en(enh_en),
        .h_factor(h_factor), .v_factor(v_factor), .h_init(h_init),
        .h_delta(h_delta), .v_init(v_init), .v_delta(v_delta)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk(req, "rejected", longint'(rejected), longint'(e_rej));
        chk(req, "div_zero", longint'(div_zero), longint'(e_dz));
        chk(req, "scale_en", longint'(scale_en), longint'(e_sc));
        chk(req, "enh_en",   longint'(enh_en),   longint'(e_enh));
        if (e_res_known) begin
            chk("R4", "h_factor", longint'(h_factor), longint'(e_res[0]));
            chk("R4", "v_factor", longint'(v_factor), longint'(e_res[1]));
            chk("R5", "h_init",   longint'(h_init),   longint'(e_res[2]));
            chk("R6", "h_delta",  longint'(h_delta),  longint'(e_res[3]));
            chk("R5", "v_init",   longint'(v_init),   longint'(e_res[4]));
            chk("R6", "v_delta",  longint'(v_delta),  longint'(e_res[5]));
        end
    endtask

    // Behavioural model: returns the expected latency in edges after start.
    function automatic int model(input logic [3:0] m, input logic [31:0] sw, input logic [31:0] sh,
                                 input logic [15:0] dw, input logic [15:0] dh);
        longint unsigned nums [6];
        longint unsigned dens [6];
        longint unsigned q;
        int ones;
        ones = $countones(m);
        for (int i = 0; i < 6; i++) e_res[i] = '0;
        e_rej = 0; e_dz = 0; e_sc = 0; e_enh = 0; e_res_known = 1;
        if (ones == 0) return 0;
        if (ones > 1) begin e_rej = 1; return 0; end
        nums[0] = longint'(dw) << 32;          dens[0] = longint'(sw);
        nums[1] = longint'(dh) << 32;          dens[1] = longint'(sh);
        nums[2] = longint'(sw >> 16) << 4;     dens[2] = longint'(dw);
        nums[3] = longint'(sw >> 16) << 16;    dens[3] = longint'(dw);
        nums[4] = longint'(sh >> 16) << 4;     dens[4] = longint'(dh);
        nums[5] = longint'(sh >> 16) << 16;    dens[5] = longint'(dh);
        for (int k = 0; k < 6; k++) begin
            if (dens[k] == 0) begin
                e_dz = 1; e_res_known = 0;
                return 2 + 66 * k;
            end
            q = nums[k] / dens[k];
            if (k == 2 || k == 4) q = (q + 1) / 2;
            e_res[k] = q[31:0];
        end
        e_sc  = 1;
        e_enh = (e_res[0][31:16] >= 2) || (e_res[1][31:16] >= 2);
        return 396;
    endfunction

    // Issue one request; compare done/busy every cycle and outputs at done and while idle after.
    task automatic run(input string req, input logic [3:0] m, input logic [31:0] sw, input logic [31:0] sh,
                       input logic [15:0] dw, input logic [15:0] dh, input int poke_at);
        int lat;
        lat = model(m, sw, sh, dw, dh);
        @(negedge clk);
        plane_mask = m; src_w = sw; src_h = sh; dst_w = dw; dst_h = dh; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc <= lat + 4; cyc++) begin
            if (cyc > 0) begin
                if (cyc == poke_at) begin
                    // R10: a stray start with a different request while busy
                    start = 1'b1; plane_mask = 4'b0011; src_w = 32'h0001_0000; dst_w = 16'd7;
                end
                @(posedge clk);
                @(negedge clk);
                start = 1'b0;
            end
            chk(req, $sformatf("done@%0d", cyc), longint'(done), longint'(cyc == lat));
            chk(req, $sformatf("busy@%0d", cyc), longint'(busy), longint'(lat > 0 && cyc < lat));
            if (cyc >= lat) chk_outputs(cyc == lat ? req : "R11");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", longint'(busy), 0);
        chk("R1", "done", longint'(done), 0);
        chk("R1", "flags", longint'({rejected, div_zero, scale_en, enh_en}), 0);
        chk("R1", "results", longint'(h_factor | v_factor | h_init | h_delta | v_init | v_delta), 0);
        rst_n = 1'b1;

        run("R3", 4'b0000, 32'd640 << 16, 32'd480 << 16, 16'd1280, 16'd960, -1);
        run("R2", 4'b0101, 32'd640 << 16, 32'd480 << 16, 16'd1280, 16'd960, -1);
        // R7 upscale by two: enhancer on
        run("R8", 4'b0010, 32'd640 << 16, 32'd480 << 16, 16'd1280, 16'd960, -1);
        // R7 downscale: enhancer off
        run("R8", 4'b1000, 32'd1920 << 16, 32'd1080 << 16, 16'd640, 16'd360, -1);
        // fractional source, odd sizes; factor just below two vertically
        run("R4", 4'b0001, 32'h0064_8000, 32'd37 << 16, 16'd333, 16'd73, -1);
        // R7 only vertical factor crosses two
        run("R7", 4'b0100, 32'd100 << 16, 32'd10 << 16, 16'd150, 16'd20, -1);
        run("R2", 4'b1111, 32'd1 << 16, 32'd1 << 16, 16'd1, 16'd1, -1);
        // R9 zero source width: first division
        run("R9", 4'b0001, 32'd0, 32'd10 << 16, 16'd20, 16'd20, -1);
        // R9 zero destination height: vertical initial phase division
        run("R9", 4'b0001, 32'd10 << 16, 32'd10 << 16, 16'd20, 16'd0, -1);
        // R10 stray start while busy is ignored
        run("R10", 4'b0010, 32'd300 << 16, 32'd200 << 16, 16'd1024, 16'd768, 100);
        run("R3", 4'b0000, 32'd1 << 16, 32'd1 << 16, 16'd1, 16'd1, -1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule